// File: doc/BRIEF.md
# I2C Bus Monitor with Glitch Rejection

This block watches an I2C bus without driving it. It takes SCL and SDA as sampled by a fast local clock, finds START and STOP conditions, and collects each byte with its acknowledge bit. Each detected condition appears as a one-cycle pulse. The last byte, its acknowledge and the address fields of the most recent address byte stay on the outputs until they are overwritten.

A glitch filter judges every bus event: a rising or falling SCL edge, a START or a STOP. It measures the number of sample periods since the event before it, of any kind. If that interval is too short, the event is discarded. The interval timer starts again on every event, including a discarded one. A threshold of zero turns the filter off.

Top module: `i2c_bus_monitor`

## Requirements
- R1: During and after a synchronous active-low reset, all pulse outputs are low, byte_o, ack_o, addr_flag_o, addr_o and rw_o are zero, and the monitor is idle.
- R2: A fall of SDA while SCL is high in both the current and previous synchronised samples is a START and gives one start_o pulse. Both lines pass through a two-flop synchroniser, so start_o is high in the cycle after the third rising clock edge that samples the new SDA level.
- R3: A rise of SDA while SCL is high is a STOP. It gives one stop_o pulse and returns the monitor to idle. A STOP while idle gives no pulse.
- R4: After a START, SDA is sampled on each rising SCL edge, MSB first. The ninth rising edge gives a byte_vld_o pulse with the eight collected bits on byte_o. On that edge ack_o is 1 if SDA was low and 0 if SDA was high.
- R5: The first byte after a START is the address byte. It is flagged by addr_flag_o=1 and loads addr_o with byte bits 7..1 and rw_o with byte bit 0. Later bytes give addr_flag_o=0 and leave addr_o and rw_o unchanged.
- R6: A START during a transfer is a repeated start. It pulses start_o, drops any partially collected bits, and makes the next byte an address byte.
- R7: Rising and falling SCL edges, STARTs and STOPs are events. An event whose distance in sample periods from the previous event is less than or equal to glitch_thr_i is discarded and has no effect on any output or on bit collection.
- R8: The interval timer restarts on every event, whether it is accepted or discarded.
- R9: glitch_thr_i equal to zero accepts every event.
- R10: The interval saturates at 65535 sample periods and does not wrap. It starts saturated after reset, so a threshold of 65535 discards every event.
- R11: While idle, only a START has an effect. SCL edges there give no output but still restart the interval timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Raw SCL sample |
| sda_i | input | 1 | Raw SDA sample |
| glitch_thr_i | input | 16 | Glitch threshold in sample periods, 0 disables |
| start_o | output | 1 | START or repeated START pulse |
| stop_o | output | 1 | STOP pulse |
| byte_vld_o | output | 1 | Byte and acknowledge captured pulse |
| byte_o | output | 8 | Last captured byte |
| ack_o | output | 1 | 1 when the last byte was acknowledged |
| addr_flag_o | output | 1 | Last byte was an address byte |
| addr_o | output | 7 | Address of the last address byte |
| rw_o | output | 1 | Read/write bit of the last address byte |

## Verification
The assertions assume that the glitch threshold changes only while the bus is quiet. They also assume that SCL and SDA never change in the same sample, because the monitor would then see an SCL edge and no START or STOP. The stimulus changes SDA only in the middle of an SCL phase and changes the threshold only during idle gaps between transfers. Glitch pulses are placed only on SCL, at distances chosen so that each one is either clearly inside or clearly outside the threshold window.

// File: rtl/i2cmon_pkg.sv
// Shared types for the I2C bus monitor.
// Assumes: a single sample clock domain after the synchroniser.
package i2cmon_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        MON_IDLE = 1'b0,
        MON_BUSY = 1'b1
    } mon_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;
endpackage

// File: rtl/i2cmon_sync.sv
// Synchronises SCL and SDA and classifies bus events from the current and
// previous synchronised samples.
// Assumes: raw inputs may be asynchronous; idle bus level is high.
module i2cmon_sync
    import i2cmon_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o,
    output logic     sda_o
);
    localparam int CUR = STAGES - 1;
    localparam int PRV = STAGES;

    logic [STAGES:0] scl_q;
    logic [STAGES:0] sda_q;

    // Shift chain: synchroniser stages plus one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_i};
            sda_q <= {sda_q[STAGES-1:0], sda_i};
        end
    end

    // Event decode: SCL edges, and SDA edges while SCL stays high.
    always_comb begin
        evt_o.scl_rise = scl_q[CUR] & ~scl_q[PRV];
        evt_o.scl_fall = ~scl_q[CUR] & scl_q[PRV];
        evt_o.start    = scl_q[CUR] & scl_q[PRV] & ~sda_q[CUR] & sda_q[PRV];
        evt_o.stop     = scl_q[CUR] & scl_q[PRV] & sda_q[CUR] & ~sda_q[PRV];
    end

    assign sda_o = sda_q[CUR];
endmodule

// File: rtl/i2cmon_glitch.sv
// Measures the samples since the previous bus event and accepts an event
// only if that interval exceeds the threshold (threshold 0 = accept all).
// Assumes: threshold is stable while events occur.
module i2cmon_glitch
    import i2cmon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_evt_t         evt_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             accept_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             evt_any;
    logic [CNT_W-1:0] gap_q;

    assign evt_any  = |evt_i;
    assign accept_o = evt_any & ((thr_i == '0) | (gap_q > thr_i));

    // Interval timer: restarts on any event, saturates otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= CNT_MAX;
        end else if (evt_any) begin
            gap_q <= CNT_ONE;
        end else if (gap_q != CNT_MAX) begin
            gap_q <= gap_q + CNT_ONE;
        end
    end

    // R8
    timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_any |=> (gap_q == CNT_ONE));

    // R10
    timer_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == CNT_MAX && !evt_any) |=> (gap_q == CNT_MAX));
endmodule

// File: rtl/i2cmon_decoder.sv
// Frame decoder: tracks idle/busy, collects 8 data bits plus acknowledge on
// accepted SCL rises, and emits start, stop and byte pulses.
// Assumes: at most one event kind per cycle; accept_i only with an event.
module i2cmon_decoder
    import i2cmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt_i,
    input  logic              accept_i,
    input  logic              sda_i,
    output logic              start_o,
    output logic              stop_o,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              ack_o,
    output logic              addr_flag_o,
    output logic [BYTE_W-2:0] addr_o,
    output logic              rw_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

    mon_state_e        state_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic              first_q;

    logic take_start, take_stop, take_bit;

    // Qualify events by acceptance and state.
    always_comb begin
        take_start = accept_i & evt_i.start;
        take_stop  = accept_i & evt_i.stop & (state_q == MON_BUSY);
        take_bit   = accept_i & evt_i.scl_rise & (state_q == MON_BUSY);
    end

    // Frame state, bit collection and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= MON_IDLE;
            bitcnt_q    <= '0;
            shift_q     <= '0;
            first_q     <= 1'b0;
            start_o     <= 1'b0;
            stop_o      <= 1'b0;
            byte_vld_o  <= 1'b0;
            byte_o      <= '0;
            ack_o       <= 1'b0;
            addr_flag_o <= 1'b0;
            addr_o      <= '0;
            rw_o        <= 1'b0;
        end else begin
            start_o    <= 1'b0;
            stop_o     <= 1'b0;
            byte_vld_o <= 1'b0;
            if (take_start) begin
                state_q  <= MON_BUSY;
                bitcnt_q <= '0;
                first_q  <= 1'b1;
                start_o  <= 1'b1;
            end else if (take_stop) begin
                state_q <= MON_IDLE;
                stop_o  <= 1'b1;
            end else if (take_bit) begin
                if (bitcnt_q == ACK_SLOT) begin
                    byte_vld_o  <= 1'b1;
                    byte_o      <= shift_q;
                    ack_o       <= ~sda_i;
                    addr_flag_o <= first_q;
                    if (first_q) begin
                        addr_o <= shift_q[BYTE_W-1:1];
                        rw_o   <= shift_q[0];
                    end
                    first_q  <= 1'b0;
                    bitcnt_q <= '0;
                end else begin
                    shift_q  <= {shift_q[BYTE_W-2:0], sda_i};
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
            end
        end
    end

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (state_q == MON_BUSY));

    // R3
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (state_q == MON_IDLE));

    // R4
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, byte_vld_o}));

    // R7
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> ($stable(state_q) && $stable(bitcnt_q) && $stable(shift_q)));
endmodule

// File: rtl/i2c_bus_monitor.sv
// Top of the passive I2C bus monitor: synchroniser and event classifier,
// glitch qualifier, frame decoder.
// Assumes: sample clock much faster than SCL; bus never driven here.
module i2c_bus_monitor
    import i2cmon_pkg::*;
#(
    parameter int THR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [THR_W-1:0] glitch_thr_i,
    output logic             start_o,
    output logic             stop_o,
    output logic             byte_vld_o,
    output logic [7:0]       byte_o,
    output logic             ack_o,
    output logic             addr_flag_o,
    output logic [6:0]       addr_o,
    output logic             rw_o
);
    bus_evt_t evt;
    logic     sda_s;
    logic     accept;

    i2cmon_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt),
        .sda_o (sda_s)
    );

    i2cmon_glitch #(.CNT_W(THR_W)) i_glitch (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .thr_i    (glitch_thr_i),
        .accept_o (accept)
    );

    i2cmon_decoder i_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .accept_i    (accept),
        .sda_i       (sda_s),
        .start_o     (start_o),
        .stop_o      (stop_o),
        .byte_vld_o  (byte_vld_o),
        .byte_o      (byte_o),
        .ack_o       (ack_o),
        .addr_flag_o (addr_flag_o),
        .addr_o      (addr_o),
        .rw_o        (rw_o)
    );
endmodule

// File: tb/test_i2c_bus_monitor.sv
module test_i2c_bus_monitor;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl = 1'b1, sda = 1'b1;
    logic [15:0] thr = 16'd0;
    logic        start_o, stop_o, byte_vld_o, ack_o, addr_flag_o, rw_o;
    logic [7:0]  byte_o;
    logic [6:0]  addr_o;

    i2c_bus_monitor i_i2c_bus_monitor (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .glitch_thr_i(thr), .start_o(start_o), .stop_o(stop_o),
        .byte_vld_o(byte_vld_o), .byte_o(byte_o), .ack_o(ack_o),
        .addr_flag_o(addr_flag_o), .addr_o(addr_o), .rw_o(rw_o)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    int hp = 4;
    int c_start = 0, c_stop = 0, c_vld = 0;

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: pin history, event time stamps, frame state.
    bit hs1, hs2, hs3, hd1, hd2, hd3;
    longint tnow = 0, tlast = -1000000;
    bit busy, first;
    int nb, sh;
    int e_start, e_stop, e_vld, e_byte, e_ack, e_flag, e_addr, e_rw;

    always @(posedge clk) begin
        if (!rst_n) begin
            {hs1, hs2, hs3, hd1, hd2, hd3} = 6'b111111;
            tlast = -1000000;
            busy = 0; first = 0; nb = 0; sh = 0;
            e_start = 0; e_stop = 0; e_vld = 0; e_byte = 0;
            e_ack = 0; e_flag = 0; e_addr = 0; e_rw = 0;
        end else begin
            bit rise, fall, st, sp, acc;
            longint iv;
            e_start = 0; e_stop = 0; e_vld = 0;
            rise = hs2 && !hs3;
            fall = !hs2 && hs3;
            st   = hs2 && hs3 && !hd2 && hd3;
            sp   = hs2 && hs3 && hd2 && !hd3;
            acc  = 0;
            if (rise || fall || st || sp) begin
                iv = tnow - tlast;
                if (iv > 65535) iv = 65535;
                acc = (thr == 0) || (iv > thr);
                tlast = tnow;
            end
            if (acc && st) begin
                busy = 1; first = 1; nb = 0; e_start = 1;
            end else if (acc && sp && busy) begin
                busy = 0; e_stop = 1;
            end else if (acc && rise && busy) begin
                if (nb == 8) begin
                    e_vld = 1; e_byte = sh & 8'hFF; e_ack = !hd2; e_flag = first;
                    if (first) begin e_addr = (sh >> 1) & 7'h7F; e_rw = sh & 1; end
                    first = 0; nb = 0;
                end else begin
                    sh = ((sh << 1) | hd2) & 8'hFF; nb++;
                end
            end
            hs3 = hs2; hs2 = hs1; hs1 = scl;
            hd3 = hd2; hd2 = hd1; hd1 = sda;
        end
        tnow++;
    end

    // Cycle compare against the reference and pulse counting.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 start_o", start_o, e_start);
            chk("R3 stop_o", stop_o, e_stop);
            chk("R4 byte_vld_o", byte_vld_o, e_vld);
            chk("R4 byte_o", byte_o, e_byte);
            chk("R4 ack_o", ack_o, e_ack);
            chk("R5 addr_flag_o", addr_flag_o, e_flag);
            chk("R5 addr_o", addr_o, e_addr);
            chk("R5 rw_o", rw_o, e_rw);
            c_start += start_o; c_stop += stop_o; c_vld += byte_vld_o;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        c_start = 0; c_stop = 0; c_vld = 0;
    endtask

    task automatic do_start();
        scl = 1; sda = 1; idle(hp);
        sda = 0; idle(hp);
        scl = 0; idle(hp);
    endtask

    task automatic do_rstart();
        sda = 1; idle(hp);
        scl = 1; idle(hp);
        sda = 0; idle(hp);
        scl = 0; idle(hp);
    endtask

    task automatic do_stop();
        sda = 0; idle(hp);
        scl = 1; idle(hp);
        sda = 1; idle(hp);
    endtask

    task automatic send_bit(bit b);
        sda = b; idle(hp);
        scl = 1; idle(hp);
        scl = 0; idle(hp);
    endtask

    // A normal bit followed by a short SCL pulse after its falling edge.
    task automatic bit_glitch(bit b, int pre, int wid, int tail);
        sda = b; idle(hp);
        scl = 1; idle(hp);
        scl = 0; idle(pre);
        scl = 1; idle(wid);
        scl = 0; idle(tail);
    endtask

    task automatic send_byte(logic [7:0] d, bit nack);
        for (int k = 7; k >= 0; k--) send_bit(d[k]);
        send_bit(nack);
    endtask

    task automatic send_byte_g(logic [7:0] d, bit nack, int gpos,
                               int pre, int wid, int tail, bit lost);
        logic [8:0] v;
        v = {d, nack};
        for (int k = 8; k >= 0; k--) begin
            if (k == gpos) begin
                bit_glitch(v[k], pre, wid, tail);
                if (lost) begin
                    scl = 1; idle(hp);
                    scl = 0; idle(hp);
                end
            end else begin
                send_bit(v[k]);
            end
        end
    endtask

    initial begin
        idle(3);
        // R1: outputs cleared under reset
        chk("R1 pulses", {start_o, stop_o, byte_vld_o}, 0);
        chk("R1 byte_o", byte_o, 0);
        chk("R1 fields", {ack_o, addr_flag_o, addr_o, rw_o}, 0);
        rst_n = 1; idle(10);

        // R4 R5: plain write of address 0x53 and a NACKed data byte
        thr = 0; hp = 4; clr();
        do_start(); send_byte(8'hA6, 0); send_byte(8'h3C, 1); do_stop(); idle(20);
        chk("R2 start count", c_start, 1);
        chk("R3 stop count", c_stop, 1);
        chk("R4 byte count", c_vld, 2);
        chk("R4 last byte", byte_o, 8'h3C);
        chk("R4 nack", ack_o, 0);
        chk("R5 addr", addr_o, 7'h53);
        chk("R5 rw", rw_o, 0);
        chk("R5 data flag", addr_flag_o, 0);

        // R6: repeated start after 4 bits
        clr();
        do_start(); send_bit(1); send_bit(0); send_bit(1); send_bit(1);
        do_rstart(); send_byte(8'h91, 0); send_byte(8'hFF, 0); do_stop(); idle(20);
        chk("R6 start count", c_start, 2);
        chk("R6 byte count", c_vld, 2);
        chk("R6 addr", addr_o, 7'h48);
        chk("R6 rw", rw_o, 1);

        // R3 R11: SCL toggles and a STOP pattern while idle
        clr();
        scl = 0; idle(5); scl = 1; idle(5); scl = 0; idle(5);
        sda = 0; idle(5); scl = 1; idle(5); sda = 1; idle(20);
        chk("R3 idle stop", c_stop, 0);
        chk("R11 idle quiet", c_start + c_vld, 0);

        // R11: an idle SCL rise restarts the timer and hides a close START
        thr = 6; clr();
        scl = 0; idle(10); scl = 1; idle(3); sda = 0; idle(10);
        scl = 0; idle(10); sda = 1; idle(10); scl = 1; idle(20);
        chk("R11 start rejected", c_start, 0);

        // R7: short SCL pulse inside a data byte is discarded
        hp = 8; clr();
        do_start(); send_byte(8'hA6, 0);
        send_byte_g(8'h5A, 0, 4, 3, 2, 8, 0); do_stop(); idle(20);
        chk("R7 byte count", c_vld, 2);
        chk("R7 byte", byte_o, 8'h5A);
        chk("R7 stop count", c_stop, 1);

        // R8: a rise close to a rejected fall is itself rejected
        clr();
        do_start(); send_byte(8'hA6, 0);
        send_byte_g(8'hC5, 0, 8, 2, 1, 4, 1); do_stop(); idle(20);
        chk("R8 byte count", c_vld, 2);
        chk("R8 byte", byte_o, 8'hC5);

        // R10: saturated interval with maximum threshold rejects everything
        thr = 16'hFFFF; hp = 4; clr();
        do_start(); send_byte(8'hA6, 0); do_stop(); idle(20);
        chk("R10 all rejected", c_start + c_stop + c_vld, 0);

        // R9: threshold zero with one-sample spacing
        thr = 0; hp = 1; clr();
        do_start(); send_byte(8'hB4, 0); send_byte(8'h01, 0); do_stop(); idle(20);
        chk("R9 byte count", c_vld, 2);
        chk("R9 byte", byte_o, 8'h01);
        chk("R9 addr", addr_o, 7'h5A);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule